// File: doc/BRIEF.md
# Associative Address Translation Buffer

This block caches a small set of page mappings and turns a 32-bit virtual address into a physical address in a single pipeline stage. Every stored slot is compared with the page number of an incoming request at the same time. The page number is the upper 20 bits of the address. The lower 12 bits are the byte offset within a 4 KB page and pass through unchanged. For each request, the response reports one of four outcomes: a translation, a miss (no slot holds the page), a page fault (a slot holds the page but marks it non-resident), or a protection fault (the kind of access is not allowed by the page's rights).

Logic outside the block handles misses and faults. On a miss it walks the page table and installs the mapping through the fill port. Each fill writes one slot. Each slot keeps a referenced flag and a modified flag. Successful accesses set these flags. Every response reports the flags as they stood when the request was accepted. A flush input empties the whole buffer in one cycle.

Requests use a valid/ready handshake and responses use a second valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and its response is presented one cycle later. While `rsp_valid` is high and `rsp_ready` is low, the response holds and no new request is taken. Fills share the slot array with lookups, so a pending fill or flush also blocks requests for that cycle.

Top module: `xlat_buffer`

## Requirements
- R1: After reset every slot is empty, `rsp_valid` is low, `req_ready` and `fill_ready` are high, and any lookup returns a miss.
- R2: A lookup compares `req_va[31:12]` against every slot. On a translation, `rsp_pa` equals the stored 20-bit frame number followed by `req_va[11:0]`.
- R3: `rsp_result` is encoded as 0 = translated, 1 = miss, 2 = page fault, 3 = protection fault. For any outcome other than 0, `rsp_pa` is zero.
- R4: The access kind is encoded as 0 = read, 1 = write, 2 = instruction fetch. Rights value 0 (read-only) allows only reads. Value 1 (read/write) allows reads and writes. Value 2 (execute-only) allows only fetches. Value 3 allows nothing. Any other pairing gives result 3.
- R5: A slot that matches with its resident flag clear gives result 2, whatever the access kind and rights.
- R6: `rsp_refd` and `rsp_dirty` show the matching slot's flags as they were before the request. A translated access sets the referenced flag. A translated write also sets the modified flag. Faults and misses change neither flag.
- R7: A fill whose page number is already stored overwrites that slot. Otherwise the fill goes to the lowest-numbered empty slot. If no slot is empty, the fill goes to the slot named by a rotating pointer. The pointer starts at 0 after reset, advances by one (wrapping) after each such eviction, and is not changed by flush.
- R8: Asserting `flush` for one cycle empties every slot, so any later lookup misses until a new fill arrives.
- R9: No more than one slot ever matches a page number.
- R10: The response appears one cycle after a request is accepted. While `rsp_valid && !rsp_ready`, the response is held unchanged and `req_ready` is low. `req_ready` is also low while `fill_valid` or `flush` is high. `fill_ready` is low during flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all slots |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_va | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind (0 read, 1 write, 2 fetch) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_result | output | 2 | Outcome code |
| rsp_pa | output | 32 | Physical address, zero unless translated |
| rsp_refd | output | 1 | Slot referenced flag before this access |
| rsp_dirty | output | 1 | Slot modified flag before this access |
| fill_valid | input | 1 | Fill request valid |
| fill_ready | output | 1 | Fill can be taken |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pfn | input | 20 | Physical frame number |
| fill_present | input | 1 | Page is resident |
| fill_rights | input | 2 | Access rights code |
| fill_dirty | input | 1 | Initial modified flag |
| fill_refd | input | 1 | Initial referenced flag |

## Verification
Some properties are checked on every cycle:
- at most one slot matches, and the fill selector picks exactly one slot;
- flush empties a slot, and a taken fill occupies its slot with the new tag;
- a translated write marks its slot modified;
- the offset passes through on a translation, and the physical address is zeroed on every fault;
- a stalled response stays frozen.

Other behaviour needs a chosen history, so only the bench scenarios can show it:
- the order in which slots are filled;
- eviction by the rotating pointer once the buffer is full, and overwriting of a duplicate page;
- the before-access reporting of the referenced and modified flags;
- the full table of access kinds against rights.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    RGT_RO   = 2'd0,
    RGT_RW   = 2'd1,
    RGT_XO   = 2'd2,
    RGT_NONE = 2'd3
  } rgt_e;

  typedef enum logic [1:0] {
    RES_HIT    = 2'd0,
    RES_MISS   = 2'd1,
    RES_PFAULT = 2'd2,
    RES_PROT   = 2'd3
  } res_e;

  typedef struct packed {
    logic             live;
    logic             present;
    logic [1:0]       rights;
    logic             dirty;
    logic             refd;
    logic [VPN_W-1:0] vpn;
    logic [PFN_W-1:0] pfn;
  } slot_t;

  function automatic logic rights_ok(input logic [1:0] rights, input logic [1:0] kind);
    logic ok;
    case (rgt_e'(rights))
      RGT_RO:  ok = (acc_e'(kind) == ACC_READ);
      RGT_RW:  ok = (acc_e'(kind) == ACC_READ) || (acc_e'(kind) == ACC_WRITE);
      RGT_XO:  ok = (acc_e'(kind) == ACC_FETCH);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/xlat_slot.sv
module xlat_slot
  import xlat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             load,
  input  slot_t            load_val,
  input  logic             touch,
  input  logic             touch_wr,
  input  logic [VPN_W-1:0] look_vpn,
  input  logic [VPN_W-1:0] fill_vpn,
  output slot_t            cur,
  output logic             look_hit,
  output logic             fill_hit
);
  slot_t st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0;
    end else if (flush) begin
      st.live <= 1'b0;
    end else if (load) begin
      st      <= load_val;
      st.live <= 1'b1;
    end else if (touch) begin
      st.refd <= 1'b1;
      if (touch_wr) st.dirty <= 1'b1;
    end
  end

  assign cur      = st;
  assign look_hit = st.live && (st.vpn == look_vpn);
  assign fill_hit = st.live && (st.vpn == fill_vpn);

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !cur.live);

  a_r7_load_occupies: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !flush) |=> (cur.live && cur.vpn == $past(load_val.vpn)));

  a_r6_write_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (touch && touch_wr && !flush && !load) |=> (cur.dirty && cur.refd));
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [ENTRIES-1:0] live,
  input  logic [ENTRIES-1:0] dup,
  output logic [ENTRIES-1:0] sel
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;
  logic             any_dup;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!live[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign any_dup = |dup;

  always_comb begin
    if (any_dup)       sel = dup;
    else if (any_free) sel = ENTRIES'(1) << free_idx;
    else               sel = ENTRIES'(1) << ptr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (fire && !any_dup && !any_free) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  a_r7_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ($countones(sel) == 1));

  a_r9_single_dup: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $onehot0(dup));
endmodule

// File: rtl/xlat_pick.sv
module xlat_pick
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  slot_t              slots [ENTRIES],
  input  logic [ENTRIES-1:0] hit,
  input  logic [1:0]         kind,
  input  logic [OFF_W-1:0]   offset,
  output res_e               res,
  output logic [PA_W-1:0]    pa,
  output logic               refd,
  output logic               dirty
);
  slot_t sel;
  logic  any;

  always_comb begin
    sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit[i]) sel = slot_t'(sel | slots[i]);
    end
  end

  assign any = |hit;

  always_comb begin
    if (!any)                          res = RES_MISS;
    else if (!sel.present)             res = RES_PFAULT;
    else if (!rights_ok(sel.rights, kind)) res = RES_PROT;
    else                               res = RES_HIT;
  end

  assign pa    = (res == RES_HIT) ? {sel.pfn, offset} : '0;
  assign refd  = sel.refd;
  assign dirty = sel.dirty;
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic [1:0]  req_kind,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [1:0]  rsp_result,
  output logic [31:0] rsp_pa,
  output logic        rsp_refd,
  output logic        rsp_dirty,
  input  logic        fill_valid,
  output logic        fill_ready,
  input  logic [19:0] fill_vpn,
  input  logic [19:0] fill_pfn,
  input  logic        fill_present,
  input  logic [1:0]  fill_rights,
  input  logic        fill_dirty,
  input  logic        fill_refd
);
  slot_t              slots [ENTRIES];
  logic [ENTRIES-1:0] look_hit;
  logic [ENTRIES-1:0] fill_hit;
  logic [ENTRIES-1:0] live;
  logic [ENTRIES-1:0] sel;
  logic               req_fire;
  logic               fill_fire;
  slot_t              load_val;
  res_e               look_res;
  logic [PA_W-1:0]    look_pa;
  logic               look_refd;
  logic               look_dirty;
  logic               hit_ok;

  assign req_ready  = (!rsp_valid || rsp_ready) && !fill_valid && !flush;
  assign fill_ready = !flush;
  assign req_fire   = req_valid && req_ready;
  assign fill_fire  = fill_valid && fill_ready;
  assign hit_ok     = req_fire && (look_res == RES_HIT);

  always_comb begin
    load_val         = '0;
    load_val.live    = 1'b1;
    load_val.present = fill_present;
    load_val.rights  = fill_rights;
    load_val.dirty   = fill_dirty;
    load_val.refd    = fill_refd;
    load_val.vpn     = fill_vpn;
    load_val.pfn     = fill_pfn;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    xlat_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .load     (fill_fire && sel[g]),
      .load_val (load_val),
      .touch    (hit_ok && look_hit[g]),
      .touch_wr (req_kind == ACC_WRITE),
      .look_vpn (req_va[VA_W-1:OFF_W]),
      .fill_vpn (fill_vpn),
      .cur      (slots[g]),
      .look_hit (look_hit[g]),
      .fill_hit (fill_hit[g])
    );
    assign live[g] = slots[g].live;
  end

  xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fill_fire),
    .live  (live),
    .dup   (fill_hit),
    .sel   (sel)
  );

  xlat_pick #(.ENTRIES(ENTRIES)) u_pick (
    .slots  (slots),
    .hit    (look_hit),
    .kind   (req_kind),
    .offset (req_va[OFF_W-1:0]),
    .res    (look_res),
    .pa     (look_pa),
    .refd   (look_refd),
    .dirty  (look_dirty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_result <= RES_MISS;
      rsp_pa     <= '0;
      rsp_refd   <= 1'b0;
      rsp_dirty  <= 1'b0;
    end else if (req_fire) begin
      rsp_valid  <= 1'b1;
      rsp_result <= look_res;
      rsp_pa     <= look_pa;
      rsp_refd   <= look_refd;
      rsp_dirty  <= look_dirty;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  a_r9_onehot_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_hit));

  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_result)));

  a_r3_fault_no_pa: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_result != RES_HIT) |-> (rsp_pa == '0));

  a_r2_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> (rsp_result != RES_HIT || rsp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0])));
endmodule

// File: tb/test_xlat_buffer.sv
module test_xlat_buffer;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_result;
  logic [31:0] rsp_pa;
  logic        rsp_refd;
  logic        rsp_dirty;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic        fill_present = 1'b0;
  logic [1:0]  fill_rights = '0;
  logic        fill_dirty = 1'b0;
  logic        fill_refd = 1'b0;

  always #4 clk = ~clk;

  xlat_buffer #(.ENTRIES(N)) i_xlat_buffer (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_result(rsp_result), .rsp_pa(rsp_pa),
    .rsp_refd(rsp_refd), .rsp_dirty(rsp_dirty),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_present(fill_present), .fill_rights(fill_rights), .fill_dirty(fill_dirty),
    .fill_refd(fill_refd)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model, built from the requirements
  bit        m_live [N];
  bit [19:0] m_vpn  [N];
  bit [19:0] m_pfn  [N];
  bit        m_pres [N];
  bit [1:0]  m_rgt  [N];
  bit        m_dirty[N];
  bit        m_refd [N];
  int        m_ptr = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit allowed(input bit [1:0] rgt, input bit [1:0] kind);
    case (rgt)
      2'd0:    return kind == 2'd0;
      2'd1:    return kind == 2'd0 || kind == 2'd1;
      2'd2:    return kind == 2'd2;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_fill(input bit [19:0] vpn, input bit [19:0] pfn, input bit pres,
                            input bit [1:0] rgt, input bit d, input bit r);
    int tgt = -1;
    for (int i = 0; i < N; i++) if (m_live[i] && m_vpn[i] == vpn) tgt = i;
    if (tgt < 0) for (int i = N - 1; i >= 0; i--) if (!m_live[i]) tgt = i;
    if (tgt < 0) begin
      tgt = m_ptr;
      m_ptr = (m_ptr + 1) % N;
    end
    m_live[tgt] = 1; m_vpn[tgt] = vpn; m_pfn[tgt] = pfn; m_pres[tgt] = pres;
    m_rgt[tgt] = rgt; m_dirty[tgt] = d; m_refd[tgt] = r;
  endtask

  // computes expected response and applies the state update
  task automatic model_look(input bit [31:0] va, input bit [1:0] kind,
                            output bit [1:0] res, output bit [31:0] pa, output bit r, output bit d);
    int idx = -1;
    for (int i = 0; i < N; i++) if (m_live[i] && m_vpn[i] == va[31:12]) idx = i;
    pa = '0; r = 0; d = 0;
    if (idx < 0) res = 2'd1;
    else begin
      r = m_refd[idx]; d = m_dirty[idx];
      if (!m_pres[idx]) res = 2'd2;
      else if (!allowed(m_rgt[idx], kind)) res = 2'd3;
      else begin
        res = 2'd0;
        pa = {m_pfn[idx], va[11:0]};
        m_refd[idx] = 1;
        if (kind == 2'd1) m_dirty[idx] = 1;
      end
    end
  endtask

  task automatic do_fill(input bit [19:0] vpn, input bit [19:0] pfn, input bit pres,
                         input bit [1:0] rgt, input bit d, input bit r);
    @(negedge clk);
    fill_valid = 1; fill_vpn = vpn; fill_pfn = pfn; fill_present = pres;
    fill_rights = rgt; fill_dirty = d; fill_refd = r;
    #1 chk("R10 req_ready low during fill", req_ready, 0);
    @(posedge clk);
    @(negedge clk);
    fill_valid = 0;
    model_fill(vpn, pfn, pres, rgt, d, r);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1;
    #1 chk("R10 fill_ready low during flush", fill_ready, 0);
    @(posedge clk);
    @(negedge clk);
    flush = 0;
    for (int i = 0; i < N; i++) m_live[i] = 0;
  endtask

  task automatic do_look(input bit [31:0] va, input bit [1:0] kind, input string req);
    bit [1:0] e_res; bit [31:0] e_pa; bit e_r, e_d;
    @(negedge clk);
    req_va = va; req_kind = kind; req_valid = 1;
    model_look(va, kind, e_res, e_pa, e_r, e_d);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk({req, " R10 rsp_valid"}, rsp_valid, 1);
    chk({req, " R3 result"}, rsp_result, e_res);
    chk({req, " R2 pa"}, rsp_pa, e_pa);
    chk({req, " R6 refd"}, rsp_refd, e_r);
    chk({req, " R6 dirty"}, rsp_dirty, e_d);
  endtask

  function automatic bit [19:0] tagv(input int k);
    return 20'hA5000 + 20'(k * 37);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    bit [31:0] held_pa;
    bit [1:0]  e_res; bit [31:0] e_pa; bit e_r, e_d;
    for (int i = 0; i < N; i++) m_live[i] = 0;
    void'($urandom(32'h1bad5eed));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    chk("R1 req_ready after reset", req_ready, 1);
    chk("R1 fill_ready after reset", fill_ready, 1);
    do_look(32'hA5000123, 2'd0, "R1 empty miss");

    // R2 R4: rights table
    do_fill(tagv(0), 20'h12345, 1, 2'd0, 0, 0);
    do_fill(tagv(1), 20'h00ABC, 1, 2'd1, 0, 0);
    do_fill(tagv(2), 20'hFFFFF, 1, 2'd2, 0, 0);
    do_fill(tagv(3), 20'h00001, 1, 2'd3, 0, 0);
    for (int t = 0; t < 4; t++)
      for (int k = 0; k < 3; k++)
        do_look({tagv(t), 12'(12'h7F0 + t * 16 + k)}, 2'(k), "R4 rights");

    // R5: non-resident page dominates rights
    do_fill(tagv(4), 20'h0BEEF, 0, 2'd3, 1, 1);
    do_look({tagv(4), 12'h004}, 2'd1, "R5 page fault");
    do_look({tagv(4), 12'h008}, 2'd2, "R5 page fault fetch");

    // R6: flags before/after
    do_fill(tagv(5), 20'h55555, 1, 2'd1, 0, 0);
    do_look({tagv(5), 12'h000}, 2'd0, "R6 first read");
    do_look({tagv(5), 12'h004}, 2'd1, "R6 first write");
    do_look({tagv(5), 12'hFFF}, 2'd0, "R6 after write");
    do_look({tagv(5), 12'h010}, 2'd2, "R6 prot no change");

    // R8 and R7 fill order then rotation
    do_flush();
    do_look({tagv(5), 12'h000}, 2'd0, "R8 miss after flush");
    for (int t = 0; t < N; t++) do_fill(tagv(10 + t), 20'(t + 1), 1, 2'd1, 0, 0);
    for (int t = 0; t < N; t++) do_look({tagv(10 + t), 12'h321}, 2'd0, "R7 all retained");
    do_fill(tagv(40), 20'h40404, 1, 2'd1, 0, 0);
    do_fill(tagv(41), 20'h41414, 1, 2'd1, 0, 0);
    do_look({tagv(10), 12'h0}, 2'd0, "R7 rotate evict slot0");
    do_look({tagv(11), 12'h0}, 2'd0, "R7 rotate evict slot1");
    do_look({tagv(12), 12'h0}, 2'd0, "R7 slot2 kept");
    do_look({tagv(41), 12'h0}, 2'd0, "R7 new entry");
    // R9 duplicate overwrite
    do_fill(tagv(12), 20'h77777, 1, 2'd0, 0, 0);
    do_look({tagv(12), 12'h0AB}, 2'd0, "R9 dup overwrite");
    do_look({tagv(13), 12'h0AB}, 2'd0, "R9 neighbour kept");

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 0;
    req_va = {tagv(14), 12'h111}; req_kind = 2'd0; req_valid = 1;
    model_look(req_va, 2'd0, e_res, e_pa, e_r, e_d);
    @(posedge clk);
    @(negedge clk);
    req_va = {tagv(15), 12'h222};
    #1;
    chk("R10 stalled req_ready", req_ready, 0);
    chk("R10 stalled rsp_valid", rsp_valid, 1);
    chk("R10 stalled pa", rsp_pa, e_pa);
    held_pa = rsp_pa;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 held pa", rsp_pa, held_pa);
    chk("R10 held result", rsp_result, e_res);
    rsp_ready = 1;
    model_look(req_va, 2'd0, e_res, e_pa, e_r, e_d);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk("R10 second rsp pa", rsp_pa, e_pa);
    chk("R10 second rsp result", rsp_result, e_res);

    // random mix
    for (int it = 0; it < 600; it++) begin
      int sel = int'($urandom_range(0, 99));
      if (sel < 30)
        do_fill(tagv(int'($urandom_range(0, 23))), 20'($urandom),
                $urandom_range(0, 9) != 0, 2'($urandom), 1'($urandom), 1'($urandom));
      else if (sel < 97)
        do_look({tagv(int'($urandom_range(0, 23))), 12'($urandom)},
                2'($urandom_range(0, 2)), "R2 R3 R4 R6 random");
      else
        do_flush();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule